// File: doc/BRIEF.md
# Address-Compressing Command Encoder

This block turns one access request into the serial command frame that a link transmitter shifts out. A request carries a slave id, a 21-bit byte address, an access size and up to four write bytes. The encoder picks the shortest address form it can use. It emits a left-aligned 64-bit message word, with the 4-bit CRC already appended, together with the total bit count. The encoder also builds the data-poll, error-poll and terminate frames, which carry no address.

The encoder remembers the word address and id of the last access that completed successfully. When a new access targets the same word, the address field shrinks to the two byte-offset bits. When the access is close to the remembered word, the field is a 9-bit signed offset. In every other case the full 21-bit address is sent. The remembered address is dropped when any of the following happens:
- an access reports failure,
- a terminate frame is built,
- a break is signalled.

The transmitter and the response logic report each access outcome back through the fin_valid/fin_ok pair.

Top module: `addr_cmd_encoder`

## Requirements
- R1: After reset, out_valid is low and no address is remembered, so the first access uses the absolute form (opcode 3'b100 in out_msg[61:59]).
- R2: Frame fields are sent most significant first, in this order: the 2-bit id (out_msg[63:62]), the opcode, a direction bit (1 = read, 0 = write), the address field, a size bit, write data, and the CRC. A 1-byte absolute read is 32 bits long.
- R3: An access whose id and word address (address bits 20:2) equal the remembered ones uses the 2-bit opcode 2'b11 and a 2-bit address field. A 1-byte read in this form is 12 bits long.
- R4: An access with the remembered id, whose byte address minus the remembered word address lies in -256..+255, uses opcode 3'b101 and a 9-bit two's complement offset. A 1-byte read in this form is 20 bits long. An offset of +256 falls back to the absolute form.
- R5: An access with an id that differs from the remembered one always uses the absolute form.
- R6: req_size 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. A 1-byte access sends size bit 0 with the address field unchanged. A 2-byte access clears field bit 0 and sends size bit 1. A 4-byte access forces field bits 1:0 to 01 and sends size bit 1.
- R7: A write appends its data bytes after the size bit, 8 bits each, starting with req_wdata[7:0]. A 4-byte absolute write is 64 bits long.
- R8: The last 4 bits are a CRC with polynomial x^4+x+1, processed MSB first. The register starts at 0, first takes a single 1 bit, and then takes every message bit.
- R9: The remembered address is replaced only when fin_valid arrives with fin_ok high for a pending access. A fin_valid with fin_ok low clears it, and the next access is absolute.
- R10: A terminate request or a brk pulse clears the remembered address.
- R11: req_kind 1 builds a data poll (id, 3'b010, CRC; 9 bits). req_kind 2 builds an error poll (id, 3'b011, CRC; 9 bits). req_kind 3 builds a terminate frame (id, 6'b111101, CRC; 12 bits). req_kind 0 is an access.
- R12: out_valid, out_msg and out_bits are registered. They reflect a request one clock after req_valid is sampled, and out_valid is low in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per frame |
| req_kind | input | 2 | 0 access, 1 data poll, 2 error poll, 3 terminate |
| req_id | input | 2 | Slave id |
| req_addr | input | 21 | Byte address |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_write | input | 1 | 1 for a write access |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| fin_valid | input | 1 | Outcome of the pending access is reported |
| fin_ok | input | 1 | Outcome was successful |
| brk | input | 1 | Link break: forget the remembered address |
| out_valid | output | 1 | Frame valid |
| out_msg | output | 64 | Frame, left-aligned, first bit in bit 63 |
| out_bits | output | 7 | Frame length in bits including CRC |

## Verification
Each frame is due exactly one clock after its request is sampled. A fin, brk or terminate changes only the address form chosen for requests sampled after the edge that takes it. The bench drives inputs on the falling edge. It moves its reference frame into the expected slot on the rising edge that registers the request, and compares it on the falling edge that follows. It also compares out_valid in every idle cycle. A behavioural model that builds a bit queue supplies the expected frame. Explicit checks pin the lengths and opcode fields that the requirements state.

// File: rtl/acenc_pkg.sv
package acenc_pkg;

  typedef enum logic [1:0] {
    KIND_ACCESS = 2'd0,
    KIND_DPOLL  = 2'd1,
    KIND_EPOLL  = 2'd2,
    KIND_TERM   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    FORM_ABS  = 2'd0,
    FORM_REL  = 2'd1,
    FORM_SAME = 2'd2
  } form_e;

  localparam logic [2:0] OP_ABS   = 3'b100;
  localparam logic [2:0] OP_REL   = 3'b101;
  localparam logic [1:0] OP_SAME  = 2'b11;
  localparam logic [2:0] OP_DPOLL = 3'b010;
  localparam logic [2:0] OP_EPOLL = 3'b011;
  localparam logic [5:0] OP_TERM  = 6'b111101;

  // one MSB-first step of the x^4+x+1 CRC
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

endpackage

// File: rtl/acenc_addr_track.sv
module acenc_addr_track
  import acenc_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  parameter int REL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fin_valid,
  input  logic              fin_ok,
  input  logic              brk,
  output form_e             form,
  output logic [ADDR_W-1:0] field
);

  localparam int WORD_W = ADDR_W - 2;

  logic              last_ok_q, last_ok_d;
  logic [ID_W-1:0]   last_id_q, last_id_d;
  logic [WORD_W-1:0] last_word_q, last_word_d;
  logic              pend_ok_q, pend_ok_d;
  logic [ID_W-1:0]   pend_id_q, pend_id_d;
  logic [WORD_W-1:0] pend_word_q, pend_word_d;
  logic              upd_en;

  logic                     id_hit, word_hit, fits;
  logic signed [ADDR_W:0]   diff;
  logic [ADDR_W-REL_W+1:0]  upper;

  // byte offset of the request from the remembered word
  assign diff  = $signed({1'b0, req_addr}) - $signed({1'b0, last_word_q, 2'b00});
  assign upper = diff[ADDR_W:REL_W-1];
  assign fits  = (&upper) | ~(|upper);

  assign id_hit   = last_ok_q && (last_id_q == req_id);
  assign word_hit = (last_word_q == req_addr[ADDR_W-1:2]);

  always_comb begin
    if (id_hit && word_hit) form = FORM_SAME;
    else if (id_hit && fits) form = FORM_REL;
    else form = FORM_ABS;
  end

  always_comb begin
    case (form)
      FORM_SAME: field = {{(ADDR_W-2){1'b0}}, req_addr[1:0]};
      FORM_REL:  field = {{(ADDR_W-REL_W){1'b0}}, diff[REL_W-1:0]};
      default:   field = req_addr;
    endcase
  end

  // next state: outcome first, then new request, break last
  always_comb begin
    last_ok_d   = last_ok_q;
    last_id_d   = last_id_q;
    last_word_d = last_word_q;
    pend_ok_d   = pend_ok_q;
    pend_id_d   = pend_id_q;
    pend_word_d = pend_word_q;
    if (fin_valid) begin
      if (fin_ok && pend_ok_q) begin
        last_ok_d   = 1'b1;
        last_id_d   = pend_id_q;
        last_word_d = pend_word_q;
      end else begin
        last_ok_d = 1'b0;
      end
      pend_ok_d = 1'b0;
    end
    if (req_valid && req_kind == KIND_ACCESS) begin
      pend_ok_d   = 1'b1;
      pend_id_d   = req_id;
      pend_word_d = req_addr[ADDR_W-1:2];
    end
    if (req_valid && req_kind == KIND_TERM) begin
      last_ok_d = 1'b0;
      pend_ok_d = 1'b0;
    end
    if (brk) begin
      last_ok_d = 1'b0;
      pend_ok_d = 1'b0;
    end
  end

  assign upd_en = fin_valid | req_valid | brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ok_q   <= 1'b0;
      last_id_q   <= '0;
      last_word_q <= '0;
      pend_ok_q   <= 1'b0;
      pend_id_q   <= '0;
      pend_word_q <= '0;
    end else if (upd_en) begin
      last_ok_q   <= last_ok_d;
      last_id_q   <= last_id_d;
      last_word_q <= last_word_d;
      pend_ok_q   <= pend_ok_d;
      pend_id_q   <= pend_id_d;
      pend_word_q <= pend_word_d;
    end
  end

endmodule

// File: rtl/acenc_frame.sv
module acenc_frame
  import acenc_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int REL_W      = 9,
  parameter int DATA_BYTES = 4,
  parameter int MSG_W      = 64,
  parameter int CNT_W      = 7
) (
  input  kind_e                     kind,
  input  logic [ID_W-1:0]           id,
  input  logic                      wr,
  input  logic [1:0]                size,
  input  logic [8*DATA_BYTES-1:0]   wdata,
  input  form_e                     form,
  input  logic [ADDR_W-1:0]         field,
  output logic [MSG_W-1:0]          body,
  output logic [CNT_W-1:0]          body_bits
);

  logic [MSG_W-1:0]  acc;
  logic [CNT_W-1:0]  n;
  logic [ADDR_W-1:0] f;
  int                nbytes;

  always_comb begin
    acc    = '0;
    n      = '0;
    f      = field;
    nbytes = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    acc = {acc[MSG_W-ID_W-1:0], id};
    n   = n + CNT_W'(ID_W);
    case (kind)
      KIND_ACCESS: begin
        if (size != 2'd0) f[0] = 1'b0;
        if (size[1]) f[1:0] = 2'b01;
        case (form)
          FORM_SAME: begin acc = {acc[MSG_W-3:0], OP_SAME}; n = n + CNT_W'(2); end
          FORM_REL:  begin acc = {acc[MSG_W-4:0], OP_REL};  n = n + CNT_W'(3); end
          default:   begin acc = {acc[MSG_W-4:0], OP_ABS};  n = n + CNT_W'(3); end
        endcase
        acc = {acc[MSG_W-2:0], ~wr};
        n   = n + CNT_W'(1);
        case (form)
          FORM_SAME: begin acc = {acc[MSG_W-3:0], f[1:0]}; n = n + CNT_W'(2); end
          FORM_REL:  begin acc = {acc[MSG_W-REL_W-1:0], f[REL_W-1:0]}; n = n + CNT_W'(REL_W); end
          default:   begin acc = {acc[MSG_W-ADDR_W-1:0], f}; n = n + CNT_W'(ADDR_W); end
        endcase
        acc = {acc[MSG_W-2:0], (size != 2'd0)};
        n   = n + CNT_W'(1);
        if (wr) begin
          for (int b = 0; b < DATA_BYTES; b++) begin
            if (b < nbytes) begin
              acc = {acc[MSG_W-9:0], wdata[8*b +: 8]};
              n   = n + CNT_W'(8);
            end
          end
        end
      end
      KIND_DPOLL: begin acc = {acc[MSG_W-4:0], OP_DPOLL}; n = n + CNT_W'(3); end
      KIND_EPOLL: begin acc = {acc[MSG_W-4:0], OP_EPOLL}; n = n + CNT_W'(3); end
      default:    begin acc = {acc[MSG_W-7:0], OP_TERM};  n = n + CNT_W'(6); end
    endcase
    body      = acc << (CNT_W'(MSG_W) - n);
    body_bits = n;
  end

endmodule

// File: rtl/acenc_crc4.sv
module acenc_crc4
  import acenc_pkg::*;
#(
  parameter int MSG_W = 64,
  parameter int CNT_W = 7,
  parameter int CRC_W = 4
) (
  input  logic [MSG_W-1:0] body,
  input  logic [CNT_W-1:0] nbits,
  output logic [CRC_W-1:0] crc
);

  localparam int SPAN = MSG_W - CRC_W;

  logic [3:0] c;

  always_comb begin
    c = crc4_step(4'b0000, 1'b1);   // implied start bit
    for (int i = 0; i < SPAN; i++) begin
      if (CNT_W'(i) < nbits) c = crc4_step(c, body[MSG_W-1-i]);
    end
    crc = c;
  end

endmodule

// File: rtl/addr_cmd_encoder.sv
module addr_cmd_encoder
  import acenc_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int REL_W      = 9,
  parameter int DATA_BYTES = 4,
  parameter int CRC_W      = 4,
  parameter int MSG_W      = 64,
  parameter int CNT_W      = $clog2(MSG_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [ID_W-1:0]         req_id,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic [8*DATA_BYTES-1:0] req_wdata,
  input  logic                    fin_valid,
  input  logic                    fin_ok,
  input  logic                    brk,
  output logic                    out_valid,
  output logic [MSG_W-1:0]        out_msg,
  output logic [CNT_W-1:0]        out_bits
);

  kind_e             kind;
  form_e             form;
  logic [ADDR_W-1:0] field;
  logic [MSG_W-1:0]  body, full;
  logic [CNT_W-1:0]  body_bits, total;
  logic [CRC_W-1:0]  crc;

  logic              valid_q, valid_d;
  logic [MSG_W-1:0]  msg_q, msg_d;
  logic [CNT_W-1:0]  bits_q, bits_d;

  assign kind = kind_e'(req_kind);

  acenc_addr_track #(.ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W)) u_track (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(kind),
    .req_id(req_id), .req_addr(req_addr), .fin_valid(fin_valid),
    .fin_ok(fin_ok), .brk(brk), .form(form), .field(field)
  );

  acenc_frame #(.ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W),
                .DATA_BYTES(DATA_BYTES), .MSG_W(MSG_W), .CNT_W(CNT_W)) u_frame (
    .kind(kind), .id(req_id), .wr(req_write), .size(req_size),
    .wdata(req_wdata), .form(form), .field(field),
    .body(body), .body_bits(body_bits)
  );

  acenc_crc4 #(.MSG_W(MSG_W), .CNT_W(CNT_W), .CRC_W(CRC_W)) u_crc (
    .body(body), .nbits(body_bits), .crc(crc)
  );

  assign full  = body | ({crc, {(MSG_W-CRC_W){1'b0}}} >> body_bits);
  assign total = body_bits + CNT_W'(CRC_W);

  always_comb begin
    valid_d = req_valid;
    msg_d   = req_valid ? full  : msg_q;
    bits_d  = req_valid ? total : bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
      bits_q  <= '0;
    end else begin
      valid_q <= valid_d;
      msg_q   <= msg_d;
      bits_q  <= bits_d;
    end
  end

  assign out_valid = valid_q;
  assign out_msg   = msg_q;
  assign out_bits  = bits_q;

endmodule

// File: rtl/acenc_checker.sv
module acenc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic [1:0]  req_id,
  input logic        brk,
  input logic        out_valid,
  input logic [63:0] out_msg,
  input logic [6:0]  out_bits
);

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  p_id_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_msg[63:62] == $past(req_id));

  p_poll_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 2'd1 || req_kind == 2'd2)) |=>
      (out_bits == 7'd9 && out_msg[61:59] == {2'b01, $past(req_kind) == 2'd2}));

  p_term_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=>
      (out_bits == 7'd12 && out_msg[61:56] == 6'b111101));

  p_break_abs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && $past(brk)) |=> out_msg[61:59] == 3'b100);

endmodule

bind addr_cmd_encoder acenc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_id(req_id), .brk(brk), .out_valid(out_valid), .out_msg(out_msg),
  .out_bits(out_bits)
);

// File: tb/tb_addr_cmd_encoder.sv
`timescale 1ns/1ps
module tb_addr_cmd_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [1:0]  req_id = 2'd0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_size = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        fin_valid = 1'b0;
  logic        fin_ok = 1'b0;
  logic        brk = 1'b0;
  logic        out_valid;
  logic [63:0] out_msg;
  logic [6:0]  out_bits;

  always #2 clk = ~clk;

  addr_cmd_encoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .fin_valid(fin_valid),
    .fin_ok(fin_ok), .brk(brk), .out_valid(out_valid), .out_msg(out_msg),
    .out_bits(out_bits)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_valid = 0; int m_id = 0; int m_word = 0;
  bit p_valid = 0; int p_id = 0; int p_word = 0;
  bit q[$];

  bit          nxt_valid = 0, exp_valid = 0;
  logic [63:0] nxt_msg = '0, exp_msg = '0;
  int          nxt_bits = 0, exp_bits = 0;
  string       nxt_tag = "R1", exp_tag = "R1";

  task automatic push(input longint v, input int w);
    for (int i = w - 1; i >= 0; i--) q.push_back(v[i]);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    exp_valid <= nxt_valid;
    exp_msg   <= nxt_msg;
    exp_bits  <= nxt_bits;
    exp_tag   <= nxt_tag;
  end

  // every-clock comparison against the model (R12 timing)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== exp_valid ||
          (exp_valid && (out_msg !== exp_msg || int'(out_bits) != exp_bits))) begin
        fails++;
        $display("FAIL %s R12 actual v=%0b msg=%h bits=%0d expected v=%0b msg=%h bits=%0d",
                 exp_tag, out_valid, out_msg, out_bits, exp_valid, exp_msg, exp_bits);
      end
    end
  end

  task automatic issue(input int kind, input int id, input int addr, input int size,
                       input bit wr, input logic [31:0] wd, input string tag,
                       input int xlen, input int xop);
    int c, fv, off, nb;
    bit same, rel;
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_id = 2'(id); req_addr = 21'(addr);
    req_size = 2'(size); req_write = wr; req_wdata = wd;
    q.delete();
    push(id, 2);
    if (kind == 0) begin
      off  = addr - m_word;
      same = m_valid && m_id == id && m_word == (addr & 'h1FFFFC);
      rel  = m_valid && m_id == id && off >= -256 && off <= 255;
      if (same) begin push(3, 2); fv = addr & 3; end
      else if (rel) begin push(5, 3); fv = off; end
      else begin push(4, 3); fv = addr; end
      push(wr ? 0 : 1, 1);
      if (size != 0) fv = fv & ~1;
      if (size >= 2) fv = (fv & ~3) | 1;
      push(fv, same ? 2 : rel ? 9 : 21);
      push(size != 0, 1);
      nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
      if (wr) for (int b = 0; b < nb; b++) push((wd >> (8*b)) & 255, 8);
      p_valid = 1; p_id = id; p_word = addr & 'h1FFFFC;
    end else if (kind == 1) push(2, 3);
    else if (kind == 2) push(3, 3);
    else begin push('h3D, 6); m_valid = 0; p_valid = 0; end
    c = 0;
    for (int i = -1; i < q.size(); i++) begin
      int b, fb;
      b  = (i < 0) ? 1 : int'(q[i]);
      fb = ((c >> 3) & 1) ^ b;
      c  = ((c << 1) & 'hF) ^ (fb ? 3 : 0);
    end
    push(c, 4);
    nxt_msg = '0;
    for (int i = 0; i < q.size(); i++) nxt_msg[63-i] = q[i];
    nxt_bits = q.size(); nxt_valid = 1; nxt_tag = tag;
    @(negedge clk);
    req_valid = 0; nxt_valid = 0;
    if (xlen >= 0) chk({tag, " length"}, out_bits, xlen);
    if (xop >= 0) chk({tag, " opcode"}, out_msg[61:59], xop);
  endtask

  task automatic finish_acc(input bit ok);
    @(negedge clk);
    fin_valid = 1; fin_ok = ok;
    if (ok && p_valid) begin m_valid = 1; m_id = p_id; m_word = p_word; end
    else m_valid = 0;
    p_valid = 0;
    @(negedge clk);
    fin_valid = 0; fin_ok = 0;
  endtask

  task automatic do_break();
    @(negedge clk);
    brk = 1; m_valid = 0; p_valid = 0;
    @(negedge clk);
    brk = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R12 watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    // R1 / R2: first access is absolute, 32 bits
    issue(0, 0, 'h1000, 2, 0, 0, "R1 R2 first read absolute", 32, 4);
    finish_acc(1);
    // R3 / R6: same word, 4-byte read: field 01, size bit 1
    issue(0, 0, 'h1000, 2, 0, 0, "R3 same-address read", 12, 7);
    chk("R6 4-byte field and size bit", out_msg[58:56], 3'b011);
    finish_acc(1);
    issue(0, 0, 'h1003, 1, 0, 0, "R6 2-byte same form", 12, 7);
    chk("R6 2-byte field and size bit", out_msg[58:56], 3'b101);
    finish_acc(1);
    // R4: +255 offset is relative
    issue(0, 0, 'h10FF, 0, 0, 0, "R4 relative +255", 20, 5);
    finish_acc(0);
    // R9: failure forgets the address
    issue(0, 0, 'h10FF, 0, 0, 0, "R9 absolute after failure", 32, 4);
    finish_acc(1);
    issue(0, 0, 'hFFC, 0, 0, 0, "R4 relative -256", 20, 5);
    finish_acc(1);
    issue(0, 0, 'h10FC, 0, 0, 0, "R4 offset +256 absolute", 32, 4);
    finish_acc(1);
    // R5: other id
    issue(0, 1, 'h10FC, 0, 0, 0, "R5 other id absolute", 32, 4);
    finish_acc(1);
    // R7: writes
    issue(0, 1, 'h10FC, 2, 1, 32'hA1B2C3D4, "R7 same-form 4-byte write", 44, 6);
    chk("R7 first byte first", out_msg[55:48], 8'hD4);
    finish_acc(1);
    issue(0, 2, 'h1ABCD, 2, 1, 32'h5566_7788, "R7 absolute 4-byte write", 64, 4);
    finish_acc(1);
    issue(0, 2, 'h1ABCD, 0, 1, 32'h0000_00EE, "R8 1-byte write crc", 20, 6);
    finish_acc(1);
    // R10: terminate then break
    issue(3, 2, 0, 0, 0, 0, "R11 terminate frame", 12, -1);
    issue(0, 2, 'h1ABCD, 0, 0, 0, "R10 absolute after terminate", 32, 4);
    finish_acc(1);
    do_break();
    issue(0, 2, 'h1ABCD, 0, 0, 0, "R10 absolute after break", 32, 4);
    finish_acc(1);
    issue(1, 3, 0, 0, 0, 0, "R11 data poll", 9, 2);
    issue(2, 1, 0, 0, 0, 0, "R11 error poll", 9, 3);
    // R9: success without pending access must not install an address
    finish_acc(1);
    issue(0, 2, 'h1ABCD, 0, 0, 0, "R9 stray success", -1, -1);
    finish_acc(1);
    // mixed traffic for R3 R4 R8 through the model
    r = 32'hACE1_2345;
    for (int k = 0; k < 400; k++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      if (r[23:20] == 4'd0) issue(3, int'(r[1:0]), 0, 0, 0, 0, "R10 random terminate", 12, -1);
      else if (r[23:20] == 4'd1) do_break();
      else if (r[23:20] == 4'd2) issue(int'(r[25:24]) % 3, int'(r[0]), 'h2000, 0, 0, 0, "R11 random", -1, -1);
      else begin
        issue(0, int'(r[0]), 'h2000 + int'((r >> 4) & 'h3FF) - 'h200, int'(r[15:14]),
              r[16], {r[7:0], r[31:8]}, "R3 R4 R8 random access", -1, -1);
        finish_acc(r[17] | r[18]);
      end
    end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule